// File: doc/BRIEF.md
# Nanosecond Time Counter With Frequency Compensation

This block keeps time for a precision-timing subsystem. A 64-bit nanosecond counter does not step by one on every reference clock edge. Instead, a 32-bit fractional accumulator adds a programmable addend on each enabled edge. Whenever that sum overflows, the counter advances by a nominal tick period held in the control word. Choosing the addend sets the average rate. Its nominal value is ceil(2^32 * f_nominal / f_reference), and the tick is 1e9 / f_nominal ns. Rewriting the addend at run time trims the frequency without touching the count.

A separate 64-bit offset is added to the counter to form the reported time. Software can therefore shift the time without disturbing the running counter. The sum is presented to neighbouring blocks every cycle.

Software reaches the block through a simple 32-bit word interface. The 64-bit counter is read low word first: that read freezes the high word for a following high read. It is written low word first: the high write commits all 64 bits at once.

Top module: `ns_time_counter`

## Requirements
- R1: After reset the counter, offset, addend, control word, pending low word, shadow word and accumulator fraction are all zero, so every register reads 0 and `time_now` is 0.
- R2: While the enable bit (control bit 0) is 1, each clock edge adds the addend to the 32-bit fraction modulo 2^32. An edge whose sum carries out adds the tick period (control bits 11:4) to the counter. After N enabled edges from a zero fraction, the counter has grown by period * floor(N * addend / 2^32).
- R3: While the enable bit is 0, the counter and the fraction hold their values.
- R4: A read of the counter low word (address 2) returns the live low 32 bits and captures the live high 32 bits into a shadow. A read of the counter high word (address 3) returns that shadow.
- R5: A write to address 2 only stores a pending low word, and the counter is unchanged. A write to address 3 loads {written data, pending low} into the counter on that edge and clears the fraction to zero.
- R6: The offset low half (address 4) and high half (address 5) are each written and read back independently.
- R7: `time_now` equals counter plus offset modulo 2^64, in the same cycle.
- R8: A write to the addend (address 1) is used from the next edge on. Neither the counter nor the fraction is reset by it, so carries follow the running sum of the addends that were used.
- R9: The control word (address 0) reads back the enable bit and the 8-bit period field, and its other bits read 0. Writing 0 to it stops the timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 3 | Word address: 0 control, 1 addend, 2 counter low, 3 counter high, 4 offset low, 5 offset high |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, valid in the same cycle |
| time_now | output | 64 | Counter plus offset |

## Verification
The bench builds the block with its default parameters: 32-bit words, a 32-bit fraction and an 8-bit period field. These values make several cases reachable within a few hundred cycles:

- Addends of one half and three sixteenths of 2^32 give carry patterns that are easy to predict.
- A period of 200 ns, starting from a counter low word of 0xFFFFFF00, crosses into the high word after a few ticks. This makes a stale, coherent shadow value visible.
- A counter value of 0x1_FFFFFFF0 and offsets with a set top bit exercise the carry between the two 32-bit halves in the counter and in the reported sum.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_ADDEND = 3'd1,
    A_CNT_LO = 3'd2,
    A_CNT_HI = 3'd3,
    A_OFF_LO = 3'd4,
    A_OFF_HI = 3'd5
  } ntc_addr_e;

  localparam int EN_BIT     = 0;
  localparam int PERIOD_LSB = 4;
endpackage

// File: rtl/ntc_accum.sv
module ntc_accum #(
  parameter int FRAC_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              clr_i,
  input  logic [FRAC_W-1:0] addend_i,
  output logic              tick_o
);
  logic [FRAC_W-1:0] frac_q;
  logic [FRAC_W:0]   sum;

  function automatic logic [FRAC_W:0] frac_add(input logic [FRAC_W-1:0] a,
                                               input logic [FRAC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  assign sum    = frac_add(frac_q, addend_i);
  assign tick_o = en_i && sum[FRAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     frac_q <= '0;
    else if (clr_i) frac_q <= '0;
    else if (en_i)  frac_q <= sum[FRAC_W-1:0];
  end

  // R5: a counter commit clears the fraction
  a_r5_frac_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> frac_q == '0);
  // R3: fraction frozen while disabled
  a_r3_frac_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !clr_i) |=> $stable(frac_q));
endmodule

// File: rtl/ntc_counter.sv
module ntc_counter #(
  parameter int CNT_W  = 64,
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic [TICK_W-1:0] period_i,
  input  logic              load_i,
  input  logic [CNT_W-1:0]  load_val_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] c,
                                            input logic [TICK_W-1:0] p);
    return c + CNT_W'(p);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= step(cnt_q, period_i);
  end

  assign cnt_o = cnt_q;

  // R5: commit loads the assembled value
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_q == $past(load_val_i));
  // R3: no movement while disabled
  a_r3_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_i) |=> $stable(cnt_q));
  // R2: a carry advances by the period in force at that edge
  a_r2_tick_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_i && !load_i) |=> (cnt_q - $past(cnt_q)) == CNT_W'($past(period_i)));
endmodule

// File: rtl/ntc_regs.sv
module ntc_regs
  import ntc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TICK_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic                re_i,
  input  logic [2:0]          addr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic [2*DATA_W-1:0] cnt_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                enable_o,
  output logic [TICK_W-1:0]   period_o,
  output logic [DATA_W-1:0]   addend_o,
  output logic [2*DATA_W-1:0] offset_o,
  output logic                load_o,
  output logic [2*DATA_W-1:0] load_val_o
);
  logic                en_q;
  logic [TICK_W-1:0]   per_q;
  logic [DATA_W-1:0]   addend_q, pend_lo_q, shadow_q;
  logic [2*DATA_W-1:0] off_q;
  logic                rd_lo;

  assign rd_lo      = re_i && (addr_i == A_CNT_LO);
  assign load_o     = we_i && (addr_i == A_CNT_HI);
  assign load_val_o = {wdata_i, pend_lo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      per_q     <= '0;
      addend_q  <= '0;
      pend_lo_q <= '0;
      off_q     <= '0;
    end else if (we_i) begin
      case (addr_i)
        A_CTRL: begin
          en_q  <= wdata_i[EN_BIT];
          per_q <= wdata_i[PERIOD_LSB +: TICK_W];
        end
        A_ADDEND: addend_q <= wdata_i;
        A_CNT_LO: pend_lo_q <= wdata_i;
        A_OFF_LO: off_q[DATA_W-1:0] <= wdata_i;
        A_OFF_HI: off_q[2*DATA_W-1:DATA_W] <= wdata_i;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shadow_q <= '0;
    else if (rd_lo) shadow_q <= cnt_i[2*DATA_W-1:DATA_W];
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL: begin
        rdata_o[EN_BIT]              = en_q;
        rdata_o[PERIOD_LSB +: TICK_W] = per_q;
      end
      A_ADDEND: rdata_o = addend_q;
      A_CNT_LO: rdata_o = cnt_i[DATA_W-1:0];
      A_CNT_HI: rdata_o = shadow_q;
      A_OFF_LO: rdata_o = off_q[DATA_W-1:0];
      A_OFF_HI: rdata_o = off_q[2*DATA_W-1:DATA_W];
      default:  rdata_o = '0;
    endcase
  end

  assign enable_o = en_q;
  assign period_o = per_q;
  assign addend_o = addend_q;
  assign offset_o = off_q;

  // R4: low read freezes the high word
  a_r4_shadow: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> shadow_q == $past(cnt_i[2*DATA_W-1:DATA_W]));
  // R4: shadow only moves on a low read
  a_r4_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo |=> $stable(shadow_q));
  // R8: rewriting the addend leaves the offset untouched
  a_r8_addend_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == A_ADDEND) |=> $stable(off_q));
endmodule

// File: rtl/ns_time_counter.sv
module ns_time_counter #(
  parameter int DATA_W = 32,
  parameter int TICK_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_we,
  input  logic                reg_re,
  input  logic [2:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [2*DATA_W-1:0] time_now
);
  localparam int CNT_W = 2 * DATA_W;

  logic              enable, tick, load;
  logic [TICK_W-1:0] period;
  logic [DATA_W-1:0] addend;
  logic [CNT_W-1:0]  cnt, offset, load_val;

  function automatic logic [CNT_W-1:0] add_time(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] o);
    return c + o;
  endfunction

  ntc_regs #(.DATA_W(DATA_W), .TICK_W(TICK_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we), .re_i(reg_re),
    .addr_i(reg_addr), .wdata_i(reg_wdata), .cnt_i(cnt),
    .rdata_o(reg_rdata), .enable_o(enable), .period_o(period),
    .addend_o(addend), .offset_o(offset), .load_o(load),
    .load_val_o(load_val)
  );

  ntc_accum #(.FRAC_W(DATA_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .en_i(enable), .clr_i(load),
    .addend_i(addend), .tick_o(tick)
  );

  ntc_counter #(.CNT_W(CNT_W), .TICK_W(TICK_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .en_i(enable), .tick_i(tick),
    .period_i(period), .load_i(load), .load_val_i(load_val), .cnt_o(cnt)
  );

  assign time_now = add_time(cnt, offset);

  // R7: reported time moves only with counter or offset
  a_r7_time_stable: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(cnt) && $stable(offset)) |-> $stable(time_now));
endmodule

// File: tb/ns_time_counter_tb_top.sv
module ns_time_counter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] time_now;

  int unsigned n_tests = 0, n_fail = 0;
  longint unsigned cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ns_time_counter dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .time_now(time_now)
  );

  task automatic check(input string req, input longint unsigned act, input longint unsigned exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, output longint unsigned edge_at);
    @(negedge clk);
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    edge_at = cyc;
    reg_we = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_re = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_re = 0;
  endtask

  task automatic rd_cnt(output longint unsigned v);
    logic [31:0] lo, hi;
    rd(3'd2, lo); rd(3'd3, hi);
    v = {hi, lo};
  endtask

  function automatic longint unsigned carries(input longint unsigned f0,
    input longint unsigned n1, input longint unsigned a1,
    input longint unsigned n2, input longint unsigned a2);
    return (f0 + n1 * a1 + n2 * a2) >> 32;
  endfunction

  longint unsigned frac_m; // bench's own model of the fraction
  longint unsigned e, w, d, cnt_m;

  task automatic t_reset;
    logic [31:0] v;
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v);
      check("R1 reset read", v, 0);
    end
    check("R1 reset time", time_now, 0);
  endtask

  task automatic t_rate;
    longint unsigned v;
    wr(3'd1, 32'h8000_0000, w);
    wr(3'd0, (32'd8 << 4) | 1, e);
    repeat (37) @(negedge clk);
    wr(3'd0, 0, d);
    frac_m = ((d - e) * 64'h8000_0000) & 64'hFFFF_FFFF;
    cnt_m = 8 * carries(0, d - e, 64'h8000_0000, 0, 0);
    rd_cnt(v);
    check("R2 rate half addend", v, cnt_m);
    check("R9 write zero stops", v != 0, 1);
  endtask

  task automatic t_addend_change;
    longint unsigned v, c;
    wr(3'd0, (32'd5 << 4) | 1, e);
    repeat (20) @(negedge clk);
    wr(3'd1, 32'h3000_0000, w);
    repeat (30) @(negedge clk);
    wr(3'd0, 0, d);
    c = carries(frac_m, w - e, 64'h8000_0000, d - w, 64'h3000_0000);
    frac_m = (frac_m + (w - e) * 64'h8000_0000 + (d - w) * 64'h3000_0000) & 64'hFFFF_FFFF;
    cnt_m = cnt_m + 5 * c;
    rd_cnt(v);
    check("R8 addend trim keeps count", v, cnt_m);
  endtask

  task automatic t_hold;
    longint unsigned v;
    logic [63:0] t0;
    t0 = time_now;
    repeat (25) @(negedge clk);
    rd_cnt(v);
    check("R3 disabled hold", v, cnt_m);
    check("R3 disabled time hold", time_now, t0);
  endtask

  task automatic t_load;
    logic [31:0] lo;
    longint unsigned v;
    wr(3'd2, 32'hFFFF_FFF0, w);
    rd(3'd2, lo);
    check("R5 pending low not visible", lo, cnt_m & 64'hFFFF_FFFF);
    wr(3'd3, 32'h1, w);
    rd_cnt(v);
    check("R5 commit value", v, 64'h1_FFFF_FFF0);
    check("R5 residual fraction nonzero", frac_m != 0, 1);
    wr(3'd1, 32'h8000_0000, w);
    wr(3'd0, (32'd8 << 4) | 1, e);
    repeat (11) @(negedge clk);
    wr(3'd0, 0, d);
    v = 0;
    rd_cnt(v);
    check("R5 fraction cleared", v, 64'h1_FFFF_FFF0 + 8 * carries(0, d - e, 64'h8000_0000, 0, 0));
    cnt_m = v;
  endtask

  task automatic t_shadow;
    logic [31:0] v;
    wr(3'd2, 32'hFFFF_FF00, w);
    wr(3'd3, 32'h2, w);
    rd(3'd2, v);
    check("R4 live low", v, 32'hFFFF_FF00);
    wr(3'd0, (32'd200 << 4) | 1, e);
    repeat (40) @(negedge clk);
    rd(3'd3, v);
    check("R4 shadow stays coherent", v, 2);
    wr(3'd0, 0, d);
    rd(3'd2, v);
    rd(3'd3, v);
    check("R4 shadow refreshed", v, 3);
  endtask

  task automatic t_offset;
    logic [31:0] v;
    longint unsigned c;
    wr(3'd4, 32'hF000_0001, w);
    wr(3'd5, 32'h0000_0010, w);
    rd(3'd4, v); check("R6 offset low", v, 32'hF000_0001);
    rd(3'd5, v); check("R6 offset high", v, 32'h10);
    rd_cnt(c);
    @(negedge clk);
    check("R7 time sum", time_now, c + 64'h10_F000_0001);
    wr(3'd5, 32'hFFFF_FFFF, w);
    rd(3'd4, v); check("R6 low unaffected by high write", v, 32'hF000_0001);
    @(negedge clk);
    check("R7 time sum wraps", time_now, c + 64'hFFFF_FFFF_F000_0001);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_FFFF, w);
    wr(3'd0, (32'd200 << 4) | 1, w);
    rd(3'd0, v); check("R9 ctrl readback", v, (32'd200 << 4) | 1);
    wr(3'd0, 32'hFFFF_FFFF, w);
    rd(3'd0, v); check("R9 ctrl unused bits zero", v, 32'hFF1);
    wr(3'd0, 0, w);
    rd(3'd0, v); check("R9 ctrl cleared", v, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_rate();
    t_addend_change();
    t_hold();
    t_load();
    t_shadow();
    t_offset();
    t_ctrl();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(8 * 50000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule